// File: doc/BRIEF.md
# Fractal pixel coordinate generator

This block holds a view of the complex plane as a center point and a per-pixel step. On a start command it streams one work item for every pixel of a raster frame into a downstream FIFO. The frame is 1024 by 768 pixels by default, so a full frame is 786432 items. Each work item carries the pixel's horizontal and vertical counts and the signed fixed-point real and imaginary coordinates of that pixel. Coordinates default to 32-bit two's complement with 29 fractional bits, which gives a range of about plus or minus 4.

Single-cycle commands come from an upstream keystroke decoder. Pan and zoom commands rewrite the view while the block is idle. Start computes the upper-left corner of the view in one cycle and then scans the raster. The coordinates are built by adding or subtracting the step rather than by multiplying. Restart abandons a scan that is in progress. The block waits whenever the FIFO reports full, and it pulses a done flag after the last item is accepted.

The step is kept as a power of two, 2^s in units of the least significant coordinate bit. Zooming changes the exponent s, and every offset becomes a shift of the step.

Top module: `fractal_coord_gen`

## Requirements
- R1: After reset, item_valid_o, busy_o and done_o are low. The view is center (CRE_INIT, CIM_INIT) with step exponent INIT_SH.
- R2: Start is cmd_i code 6 with cmd_valid_i high while idle. busy_o rises on the next cycle and item_valid_o on the cycle after. The first item is h=0, v=0, re = center_re - (H_PIXELS/2)*step and im = center_im + (V_LINES/2)*step.
- R3: Items run left to right within a line and top to bottom across lines, exactly H_PIXELS*V_LINES per start. The real part is center_re + (h - H_PIXELS/2)*step and the imaginary part is center_im + (V_LINES/2 - v)*step, with arithmetic modulo 2^COORD_W.
- R4: In item_data_o, bits [9:0] hold h and bits [19:10] hold v, both zero-extended. The real part sits in [COORD_W+19:20] and the imaginary part in the top COORD_W bits.
- R5: An item is taken only in a cycle where item_valid_o is high and fifo_full_i is low. While fifo_full_i is high, item_valid_o stays high and item_data_o stays unchanged.
- R6: Pan codes while idle: 0 (up) adds PAN_STEPS*step to center_im, 1 (down) subtracts it, 2 (left) subtracts PAN_STEPS*step from center_re, and 3 (right) adds it.
- R7: Zoom code 4 (in) lowers the step exponent by one, halving the step, but not below 0. Code 5 (out) raises it by one, doubling the step, but not above MAX_SH. At a limit the command has no effect.
- R8: Restart (code 7) in any cycle ends a scan. On the next cycle item_valid_o, busy_o and done_o are low, even when restart falls on the cycle of the final push.
- R9: done_o is high for exactly one cycle, the cycle after the final item is accepted. item_valid_o is low from then on.
- R10: Pan, zoom and start commands that arrive while busy_o is high have no effect on the current scan or on the view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_i | input | 3 | Command code: 0 up, 1 down, 2 left, 3 right, 4 zoom in, 5 zoom out, 6 start, 7 restart |
| fifo_full_i | input | 1 | Downstream FIFO full |
| item_valid_o | output | 1 | Work item present on item_data_o |
| item_data_o | output | 2*COORD_W+20 | {im, re, v, h} work item |
| busy_o | output | 1 | Corner computation or scan in progress |
| done_o | output | 1 | One-cycle pulse after the final item is accepted |

## Verification
Two events can fall in the same cycle: a restart and the push of the frame's final item. The bench provokes this by holding the FIFO not-full and driving restart in the exact cycle the last item is offered. It then requires that valid, busy and done are all low on the following cycle, so restart wins and no done pulse appears. A second collision is a pan, zoom or start command arriving during a scan while the FIFO stalls at random. It is judged by checking every later item of that frame, and every item of the next frame, against the unchanged view model.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam int HFIELD_W = 10;
  localparam int VFIELD_W = 10;

  typedef enum logic [2:0] {
    CMD_PAN_UP    = 3'd0,
    CMD_PAN_DOWN  = 3'd1,
    CMD_PAN_LEFT  = 3'd2,
    CMD_PAN_RIGHT = 3'd3,
    CMD_ZOOM_IN   = 3'd4,
    CMD_ZOOM_OUT  = 3'd5,
    CMD_START     = 3'd6,
    CMD_RESTART   = 3'd7
  } fcg_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CORNER = 2'd1,
    ST_SCAN   = 2'd2
  } fcg_state_e;
endpackage

// File: rtl/fcg_view_reg.sv
module fcg_view_reg
  import fcg_pkg::*;
#(
  parameter int COORD_W   = 32,
  parameter int MAX_SH    = 21,
  parameter int INIT_SH   = 21,
  parameter int PAN_STEPS = 64,
  parameter int CRE_INIT  = -(2**28),
  parameter int CIM_INIT  = 0,
  localparam int SH_W     = $clog2(MAX_SH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               busy_i,
  input  logic               cmd_valid_i,
  input  fcg_cmd_e           cmd_i,
  output logic [COORD_W-1:0] center_re_o,
  output logic [COORD_W-1:0] center_im_o,
  output logic [SH_W-1:0]    step_sh_o
);
  logic [COORD_W-1:0] cre_q, cim_q, pan_off;
  logic [SH_W-1:0]    sh_q;

  assign pan_off = COORD_W'(PAN_STEPS) << sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cre_q <= COORD_W'(CRE_INIT);
      cim_q <= COORD_W'(CIM_INIT);
      sh_q  <= SH_W'(INIT_SH);
    end else if (cmd_valid_i && !busy_i) begin
      case (cmd_i)
        CMD_PAN_UP:    cim_q <= cim_q + pan_off;
        CMD_PAN_DOWN:  cim_q <= cim_q - pan_off;
        CMD_PAN_LEFT:  cre_q <= cre_q - pan_off;
        CMD_PAN_RIGHT: cre_q <= cre_q + pan_off;
        CMD_ZOOM_IN:   if (sh_q != '0) sh_q <= sh_q - SH_W'(1);
        CMD_ZOOM_OUT:  if (sh_q != SH_W'(MAX_SH)) sh_q <= sh_q + SH_W'(1);
        default: ;
      endcase
    end
  end

  assign center_re_o = cre_q;
  assign center_im_o = cim_q;
  assign step_sh_o   = sh_q;

  AST_VIEW_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni) busy_i |=> ($stable(cre_q) && $stable(cim_q) && $stable(sh_q))) else $error("view changed while busy"); // R10
  AST_SHIFT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni) (cmd_valid_i && cmd_i == CMD_ZOOM_OUT && sh_q == SH_W'(MAX_SH)) |=> (sh_q == SH_W'(MAX_SH))) else $error("zoom out past limit"); // R7
endmodule

// File: rtl/fcg_raster_scan.sv
module fcg_raster_scan
  import fcg_pkg::*;
#(
  parameter int H_PIXELS = 1024,
  parameter int V_LINES  = 768,
  parameter int COORD_W  = 32,
  parameter int SH_W     = 5,
  localparam int HCNT_W  = $clog2(H_PIXELS),
  localparam int VCNT_W  = $clog2(V_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               abort_i,
  input  logic [COORD_W-1:0] center_re_i,
  input  logic [COORD_W-1:0] center_im_i,
  input  logic [SH_W-1:0]    step_sh_i,
  input  logic               fifo_full_i,
  output logic               valid_o,
  output logic [HCNT_W-1:0]  h_o,
  output logic [VCNT_W-1:0]  v_o,
  output logic [COORD_W-1:0] re_o,
  output logic [COORD_W-1:0] im_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam logic [COORD_W-1:0] H_HALF = COORD_W'(H_PIXELS / 2);
  localparam logic [COORD_W-1:0] V_HALF = COORD_W'(V_LINES / 2);

  fcg_state_e         state_q;
  logic [HCNT_W-1:0]  h_q;
  logic [VCNT_W-1:0]  v_q;
  logic [COORD_W-1:0] cur_re_q, cur_im_q, left_re_q, step;
  logic [SH_W-1:0]    sh_q;
  logic               done_q, push, h_last, v_last;

  assign step   = {{(COORD_W-1){1'b0}}, 1'b1} << sh_q;
  assign push   = (state_q == ST_SCAN) && !fifo_full_i;
  assign h_last = (h_q == HCNT_W'(H_PIXELS - 1));
  assign v_last = (v_q == VCNT_W'(V_LINES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      h_q       <= '0;
      v_q       <= '0;
      cur_re_q  <= '0;
      cur_im_q  <= '0;
      left_re_q <= '0;
      sh_q      <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          sh_q    <= step_sh_i;
          state_q <= ST_CORNER;
        end
        ST_CORNER: begin
          // corner from shifts: offsets are half-frame counts of a power-of-two step
          left_re_q <= center_re_i - (H_HALF << sh_q);
          cur_re_q  <= center_re_i - (H_HALF << sh_q);
          cur_im_q  <= center_im_i + (V_HALF << sh_q);
          h_q       <= '0;
          v_q       <= '0;
          state_q   <= ST_SCAN;
        end
        ST_SCAN: if (push) begin
          if (h_last) begin
            h_q      <= '0;
            cur_re_q <= left_re_q;
            cur_im_q <= cur_im_q - step;
            v_q      <= v_q + VCNT_W'(1);
            if (v_last) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end else begin
            h_q      <= h_q + HCNT_W'(1);
            cur_re_q <= cur_re_q + step;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (abort_i) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b0;
      end
    end
  end

  assign valid_o = (state_q == ST_SCAN);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign h_o     = h_q;
  assign v_o     = v_q;
  assign re_o    = cur_re_q;
  assign im_o    = cur_im_q;

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_o && fifo_full_i && !abort_i) |=> (valid_o && $stable(h_q) && $stable(v_q) && $stable(cur_re_q) && $stable(cur_im_q))) else $error("item moved during stall"); // R5
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) abort_i |=> (!valid_o && !busy_o && !done_o)) else $error("restart did not idle"); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |-> $past(valid_o && !fifo_full_i && h_last && v_last)) else $error("done without final push"); // R9
  AST_SCAN_CONTINUES: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_o && !abort_i && !(h_last && v_last)) |=> valid_o) else $error("scan dropped early"); // R3
endmodule

// File: rtl/fcg_word_pack.sv
module fcg_word_pack
  import fcg_pkg::*;
#(
  parameter int COORD_W = 32,
  parameter int HCNT_W  = 10,
  parameter int VCNT_W  = 10,
  localparam int WORD_W = 2 * COORD_W + HFIELD_W + VFIELD_W
) (
  input  logic [HCNT_W-1:0]  h_i,
  input  logic [VCNT_W-1:0]  v_i,
  input  logic [COORD_W-1:0] re_i,
  input  logic [COORD_W-1:0] im_i,
  output logic [WORD_W-1:0]  word_o
);
  assign word_o = {im_i, re_i, VFIELD_W'(v_i), HFIELD_W'(h_i)};
endmodule

// File: rtl/fractal_coord_gen.sv
module fractal_coord_gen
  import fcg_pkg::*;
#(
  parameter int H_PIXELS  = 1024,
  parameter int V_LINES   = 768,
  parameter int COORD_W   = 32,
  parameter int MAX_SH    = 21,
  parameter int INIT_SH   = 21,
  parameter int PAN_STEPS = 64,
  parameter int CRE_INIT  = -(2**28),
  parameter int CIM_INIT  = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  input  logic [2:0]              cmd_i,
  input  logic                    fifo_full_i,
  output logic                    item_valid_o,
  output logic [2*COORD_W+19:0]   item_data_o,
  output logic                    busy_o,
  output logic                    done_o
);
  localparam int SH_W   = $clog2(MAX_SH + 1);
  localparam int HCNT_W = $clog2(H_PIXELS);
  localparam int VCNT_W = $clog2(V_LINES);

  fcg_cmd_e           cmd;
  logic               start_go, abort, busy;
  logic [COORD_W-1:0] cre, cim, re, im;
  logic [SH_W-1:0]    sh;
  logic [HCNT_W-1:0]  h;
  logic [VCNT_W-1:0]  v;

  assign cmd      = fcg_cmd_e'(cmd_i);
  assign start_go = cmd_valid_i && (cmd == CMD_START) && !busy;
  assign abort    = cmd_valid_i && (cmd == CMD_RESTART);

  fcg_view_reg #(
    .COORD_W(COORD_W), .MAX_SH(MAX_SH), .INIT_SH(INIT_SH),
    .PAN_STEPS(PAN_STEPS), .CRE_INIT(CRE_INIT), .CIM_INIT(CIM_INIT)
  ) u_view (
    .clk_i, .rst_ni, .busy_i(busy), .cmd_valid_i, .cmd_i(cmd),
    .center_re_o(cre), .center_im_o(cim), .step_sh_o(sh)
  );

  fcg_raster_scan #(
    .H_PIXELS(H_PIXELS), .V_LINES(V_LINES), .COORD_W(COORD_W), .SH_W(SH_W)
  ) u_scan (
    .clk_i, .rst_ni, .start_i(start_go), .abort_i(abort),
    .center_re_i(cre), .center_im_i(cim), .step_sh_i(sh),
    .fifo_full_i, .valid_o(item_valid_o), .h_o(h), .v_o(v),
    .re_o(re), .im_o(im), .busy_o(busy), .done_o
  );

  fcg_word_pack #(
    .COORD_W(COORD_W), .HCNT_W(HCNT_W), .VCNT_W(VCNT_W)
  ) u_pack (
    .h_i(h), .v_i(v), .re_i(re), .im_i(im), .word_o(item_data_o)
  );

  assign busy_o = busy;

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) start_go |=> busy_o) else $error("start not taken"); // R2
endmodule

// File: tb/fractal_coord_gen_bench.sv
module fractal_coord_gen_bench;
  localparam int H = 32;
  localparam int V = 8;
  localparam int TOTAL = H * V;
  localparam int W = 32;
  localparam int MAXS = 21;
  localparam int PAN = 64;
  localparam int CRE0 = -(2**28);
  localparam int CIM0 = 12345;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic fifo_full = 1'b0;
  logic item_valid, busy, done;
  logic [2*W+19:0] data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [W-1:0] m_cre, m_cim;
  int m_sh;

  always #2.5 clk = ~clk;

  fractal_coord_gen #(
    .H_PIXELS(H), .V_LINES(V), .COORD_W(W), .MAX_SH(MAXS), .INIT_SH(MAXS),
    .PAN_STEPS(PAN), .CRE_INIT(CRE0), .CIM_INIT(CIM0)
  ) u_fractal_coord_gen (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .fifo_full_i(fifo_full), .item_valid_o(item_valid), .item_data_o(data),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2*W+19:0] exp_word(input int idx);
    int hh = idx % H;
    int vv = idx / H;
    logic [W-1:0] step = 32'd1 << m_sh;
    logic [W-1:0] re = m_cre - (W'(H / 2) << m_sh) + W'(hh) * step;
    logic [W-1:0] im = m_cim + (W'(V / 2) << m_sh) - W'(vv) * step;
    return {im, re, 10'(vv), 10'(hh)};
  endfunction

  function automatic void model_cmd(input logic [2:0] c);
    logic [W-1:0] off = W'(PAN) << m_sh;
    case (c)
      3'd0: m_cim = m_cim + off;
      3'd1: m_cim = m_cim - off;
      3'd2: m_cre = m_cre - off;
      3'd3: m_cre = m_cre + off;
      3'd4: if (m_sh > 0) m_sh = m_sh - 1;
      3'd5: if (m_sh < MAXS) m_sh = m_sh + 1;
      default: ;
    endcase
  endfunction

  task automatic send_cmd(input logic [2:0] c);
    cmd_valid = 1'b1;
    cmd = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    model_cmd(c);
  endtask

  // abort_at: item index at which restart is driven (-1 none); inj_at: item index for a busy-time command
  task automatic run_frame(input int stall_pct, input int inj_at, input logic [2:0] inj_cmd, input int abort_at);
    int idx = 0;
    int guard = 0;
    bit aborted = 0;
    bit injected = 0;
    bit prev_stall = 0;
    logic [2*W+19:0] prev_data = '0;
    bit full;
    cmd_valid = 1'b1;
    cmd = 3'd6;
    fifo_full = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && !item_valid, "R2 busy next cycle", {busy, item_valid}, 2'b10);
    while (idx < TOTAL && !aborted && guard < 20000) begin
      guard++;
      cmd_valid = 1'b0;
      if (prev_stall) chk(item_valid && data == prev_data, "R5 stall hold", data, prev_data);
      full = ($urandom_range(99) < stall_pct);
      if (item_valid && idx == abort_at) begin
        full = 1'b0;
        cmd_valid = 1'b1;
        cmd = 3'd7;
        aborted = 1;
      end else if (item_valid && idx == inj_at && !injected) begin
        cmd_valid = 1'b1;
        cmd = inj_cmd;
        injected = 1;
      end
      fifo_full = full;
      prev_stall = item_valid && full;
      prev_data = data;
      if (item_valid && !full) begin
        chk(data == exp_word(idx), (idx == 0) ? "R2 first item" : "R3 R4 item", data, exp_word(idx));
        idx++;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    fifo_full = 1'b0;
    if (aborted) begin
      chk(!item_valid && !busy && !done, "R8 restart idles", {item_valid, busy, done}, 3'b000);
      @(negedge clk);
      chk(!done && !item_valid, "R8 no late done", {item_valid, done}, 2'b00);
    end else begin
      chk(idx == TOTAL, "R3 item count", idx, TOTAL);
      chk(done && !item_valid && !busy, "R9 done pulse", {done, item_valid, busy}, 3'b100);
      @(negedge clk);
      chk(!done && !item_valid, "R9 done one cycle", {done, item_valid}, 2'b00);
    end
  endtask

  initial begin
    m_cre = W'(CRE0);
    m_cim = W'(CIM0);
    m_sh = MAXS;
    void'($urandom(32'd7151));
    repeat (3) @(negedge clk);
    chk(!item_valid && !busy && !done, "R1 reset outputs", {item_valid, busy, done}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!item_valid && !busy && !done, "R1 after release", {item_valid, busy, done}, 3'b000);

    run_frame(0, -1, 3'd0, -1);                 // R2 R3 R4 R9
    run_frame(60, -1, 3'd0, -1);                // R5
    send_cmd(3'd0); run_frame(20, -1, 3'd0, -1); // R6 up
    send_cmd(3'd1); send_cmd(3'd1); run_frame(20, -1, 3'd0, -1); // R6 down
    send_cmd(3'd2); run_frame(20, -1, 3'd0, -1); // R6 left
    send_cmd(3'd3); send_cmd(3'd3); run_frame(20, -1, 3'd0, -1); // R6 right
    repeat (3) send_cmd(3'd4);
    run_frame(30, -1, 3'd0, -1);                // R7 zoom in
    repeat (25) send_cmd(3'd4);
    chk(m_sh == 0, "R7 model floor", m_sh, 0);
    run_frame(10, -1, 3'd0, -1);                // R7 at floor
    repeat (30) send_cmd(3'd5);
    run_frame(10, -1, 3'd0, -1);                // R7 at ceiling
    run_frame(40, 5, 3'd2, -1);                 // R10 pan while busy
    run_frame(0, 9, 3'd4, -1);                  // R10 zoom while busy
    run_frame(30, 7, 3'd6, -1);                 // R10 start while busy
    run_frame(0, -1, 3'd0, -1);                 // R10 view untouched
    run_frame(30, -1, 3'd0, 40);                // R8 mid-frame restart
    run_frame(0, -1, 3'd0, TOTAL - 1);          // R8 restart with final push
    run_frame(25, -1, 3'd0, -1);                // R8 recovery
    for (int r = 0; r < 6; r++) begin
      int n = $urandom_range(4, 1);
      for (int k = 0; k < n; k++) send_cmd(3'($urandom_range(5)));
      run_frame($urandom_range(70), -1, 3'd0, -1);
    end
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule